// File: doc/BRIEF.md
# Three-Source Packet Priority Arbiter

This block merges three packet streams onto one transmit stream that feeds an Ethernet MAC. Source 0 carries timing-sync packets, source 1 carries high-rate fronthaul data and source 2 carries management and all other traffic. Every stream uses valid/ready with start-of-packet and end-of-packet flags. Packets on the sync and management inputs already carry their MAC header. The arbiter passes every beat through unchanged. It does not buffer and it does not parse packets.

A choice is made only when no packet is in flight. The order is fixed: sync first, then fronthaul, then management. The chosen source keeps the output until its end-of-packet beat has been accepted. A grant counter counts the packets started by the sync and fronthaul sources and stops at a programmable threshold. Once the counter has reached the threshold, a pending management packet wins the next decision, and the counter returns to zero.

Back-pressure rules: the output ready reaches the granted input combinationally, in the same cycle. Inputs that are not granted see ready low. A source may drop valid in the middle of a packet. Doing so stalls the output without releasing the grant. A beat is transferred on an input in any cycle where that input's valid and ready are both high.

Top module: `pkt_prio_arb`

## Requirements
- R1: After reset, no source is granted and the grant counter is zero. With all inputs idle, `m_valid` and every `s_ready` bit are low. If the threshold is 1 and sync and management both start a packet, sync wins.
- R2: While no packet is in flight, a source is requesting when it presents valid with start-of-packet. Among requesting sources, sync (index 0) beats fronthaul (index 1), which beats management (index 2). `m_valid` is low when no input is valid.
- R3: When sync and fronthaul both request at a packet boundary, `s_ready[1]` stays low.
- R4: When a beat without end-of-packet is accepted at the output, the same source stays granted. No other source's beat appears until the end-of-packet beat has been accepted.
- R5: `s_ready` equals `m_ready` on the bit of the granted source and is zero elsewhere. It is all zero when no source is granted.
- R6: Each packet start from source 0 or 1 increments the counter, up to `thresh_i`. While the counter is at least `thresh_i`, a requesting management source wins over the others. Starting that management packet clears the counter.
- R7: With `thresh_i` = 10 and all three sources always pending, the output carries one management packet for every ten sync or fronthaul packets.
- R8: A promotion stays armed while management has nothing pending. The next management request then wins, even against sync.
- R9: `m_data`, `m_sop` and `m_eop` equal the granted input's data and flags in the same cycle. `m_data` bits [15:14] in the bench carry the source index.
- R10: If the granted source drops valid in the middle of a packet, `m_valid` goes low and the grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh_i | input | CNT_W | Grant count that promotes management |
| s_valid | input | 3 | Per-source valid (0 sync, 1 fronthaul, 2 management) |
| s_ready | output | 3 | Per-source ready |
| s_sop | input | 3 | Per-source start-of-packet |
| s_eop | input | 3 | Per-source end-of-packet |
| s_data | input | 3*DATA_W | Per-source data, source i in slice i |
| m_valid | output | 1 | Output valid |
| m_ready | input | 1 | Output ready from MAC |
| m_sop | output | 1 | Output start-of-packet |
| m_eop | output | 1 | Output end-of-packet |
| m_data | output | DATA_W | Output data |

## Verification
Forwarding and ready propagation are combinational. `m_valid`, `m_data`, the flags and `s_ready` therefore respond in the same cycle as the inputs that cause them. The bench drives inputs on the falling edge and samples one time unit later, before the next rising edge. Grant lock and counter state change on the rising edge after an accepted beat. The bench model updates its own lock and counter state after each sample, so the next cycle's expectations already include the new state. The grant ratio and the armed promotion are checked from the source index carried in the data of each packet start seen at the output.

// File: rtl/pkt_arb_pkg.sv
package pkt_arb_pkg;
  localparam int NSRC = 3;
  typedef enum logic [1:0] {
    SRC_SYNC = 2'd0,
    SRC_FH   = 2'd1,
    SRC_MGMT = 2'd2
  } src_e;
endpackage

// File: rtl/pkt_arb_pick.sv
module pkt_arb_pick
  import pkt_arb_pkg::*;
(
  input  logic [NSRC-1:0] req,
  input  logic            promo,
  output logic            any,
  output src_e            sel
);
  always_comb begin
    any = |req;
    sel = SRC_MGMT;
    if (promo && req[SRC_MGMT]) sel = SRC_MGMT;
    else if (req[SRC_SYNC])     sel = SRC_SYNC;
    else if (req[SRC_FH])       sel = SRC_FH;
  end
endmodule

// File: rtl/pkt_arb_credit.sv
module pkt_arb_credit
  import pkt_arb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thresh,
  input  logic             start,
  input  src_e             start_src,
  output logic             promo,
  output logic [CNT_W-1:0] cnt
);
  assign promo = (cnt >= thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      if (start_src == SRC_MGMT) begin
        if (promo) cnt <= '0;
      end else if (cnt < thresh) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_arb_mux.sv
module pkt_arb_mux
  import pkt_arb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  src_e                   sel,
  input  logic [NSRC-1:0]        valid,
  input  logic [NSRC-1:0]        sop,
  input  logic [NSRC-1:0]        eop,
  input  logic [NSRC*DATA_W-1:0] data,
  output logic                   o_valid,
  output logic                   o_sop,
  output logic                   o_eop,
  output logic [DATA_W-1:0]      o_data
);
  logic [NSRC-1:0]        hit;
  logic [NSRC*DATA_W-1:0] masked;

  for (genvar g = 0; g < NSRC; g++) begin : g_lane
    assign hit[g] = (sel == src_e'(g));
    assign masked[g*DATA_W +: DATA_W] = hit[g] ? data[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    o_data = '0;
    for (int i = 0; i < NSRC; i++) o_data |= masked[i*DATA_W +: DATA_W];
  end

  assign o_valid = |(hit & valid);
  assign o_sop   = |(hit & sop);
  assign o_eop   = |(hit & eop);
endmodule

// File: rtl/pkt_prio_arb.sv
module pkt_prio_arb
  import pkt_arb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       thresh_i,
  input  logic [NSRC-1:0]        s_valid,
  output logic [NSRC-1:0]        s_ready,
  input  logic [NSRC-1:0]        s_sop,
  input  logic [NSRC-1:0]        s_eop,
  input  logic [NSRC*DATA_W-1:0] s_data,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic                   m_sop,
  output logic                   m_eop,
  output logic [DATA_W-1:0]      m_data
);
  logic             busy_q;
  src_e             owner_q;
  logic             pick_any;
  src_e             pick_sel;
  src_e             cur;
  logic             have;
  logic             mx_valid;
  logic             fire;
  logic             start;
  logic             promo;
  logic [CNT_W-1:0] cnt;

  pkt_arb_pick u_pick (
    .req   (s_valid & s_sop),
    .promo (promo),
    .any   (pick_any),
    .sel   (pick_sel)
  );

  assign cur  = busy_q ? owner_q : pick_sel;
  assign have = busy_q | pick_any;

  pkt_arb_mux #(.DATA_W(DATA_W)) u_mux (
    .sel     (cur),
    .valid   (s_valid),
    .sop     (s_sop),
    .eop     (s_eop),
    .data    (s_data),
    .o_valid (mx_valid),
    .o_sop   (m_sop),
    .o_eop   (m_eop),
    .o_data  (m_data)
  );

  assign m_valid = have & mx_valid;
  assign fire    = m_valid & m_ready;
  assign start   = fire & ~busy_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_rdy
    assign s_ready[g] = have & m_ready & (cur == src_e'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= SRC_SYNC;
    end else if (fire) begin
      busy_q  <= ~m_eop;
      owner_q <= cur;
    end
  end

  pkt_arb_credit #(.CNT_W(CNT_W)) u_credit (
    .clk       (clk),
    .rst_n     (rst_n),
    .thresh    (thresh_i),
    .start     (start),
    .start_src (cur),
    .promo     (promo),
    .cnt       (cnt)
  );
endmodule

// File: rtl/pkt_prio_arb_chk.sv
module pkt_prio_arb_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       s_valid,
  input logic [2:0]       s_sop,
  input logic [2:0]       s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic             m_eop,
  input logic             promo,
  input logic             start,
  input logic [1:0]       cur,
  input logic [CNT_W-1:0] cnt
);
  p_no_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|s_valid) |-> !m_valid);

  p_sync_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid[0] && s_sop[0] && s_valid[1] && s_sop[1]) |-> !s_ready[1]);

  p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !m_eop) |=> (s_ready == 3'b000 || s_ready == $past(s_ready)));

  p_one_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_ready));

  p_ready_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ($countones(s_ready) == (m_ready ? 1 : 0)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cur == 2'd2 && promo) |=> (cnt == '0));
endmodule

bind pkt_prio_arb pkt_prio_arb_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_sop   (s_sop),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_eop   (m_eop),
  .promo   (promo),
  .start   (start),
  .cur     (cur),
  .cnt     (cnt)
);

// File: tb/pkt_prio_arb_test.sv
module pkt_prio_arb_test;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] thresh_i = 8'd10;
  logic [2:0]    s_valid = '0, s_sop = '0, s_eop = '0, s_ready;
  logic [3*DW-1:0] s_data = '0;
  logic          m_valid, m_ready = 1'b0, m_sop, m_eop;
  logic [DW-1:0] m_data;

  pkt_prio_arb #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .thresh_i(thresh_i),
    .s_valid(s_valid), .s_ready(s_ready), .s_sop(s_sop), .s_eop(s_eop), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_sop(m_sop), .m_eop(m_eop), .m_data(m_data)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int act[3], pos[3], len[3], seq[3], pstart[3];
  int pgap = 0, prdy = 100, lenfix = 0;
  bit mbusy; int mowner; int mcnt;
  int starts = 0, mg = 0, last_src = -1;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint a, input longint e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic int pick(input bit busy, input int owner, input int cnt,
                              input int thr, input logic [2:0] req);
    if (busy) return owner;
    if (cnt >= thr && req[2]) return 2;
    if (req[0]) return 0;
    if (req[1]) return 1;
    if (req[2]) return 2;
    return -1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_valid = '0; s_sop = '0; s_eop = '0; m_ready = 1'b0;
    for (int s = 0; s < 3; s++) begin act[s] = 0; pos[s] = 0; end
    mbusy = 0; mowner = 0; mcnt = 0;
    starts = 0; mg = 0; last_src = -1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step();
    int cur, thr;
    bit promo, have, ev, fire;
    logic [2:0] exp_rdy, req;
    @(negedge clk);
    for (int s = 0; s < 3; s++) begin
      if (act[s] == 0 && ($urandom % 100) < pstart[s]) begin
        act[s] = 1; pos[s] = 0;
        len[s] = (lenfix > 0) ? lenfix : 1 + int'($urandom % 5);
      end
      s_valid[s] = (act[s] != 0) && (($urandom % 100) >= pgap);
      s_sop[s]   = (pos[s] == 0);
      s_eop[s]   = (pos[s] == len[s] - 1);
      s_data[s*DW +: DW] = {2'(s), 6'(seq[s]), 8'(pos[s])};
    end
    m_ready = ($urandom % 100) < prdy;
    #1;
    thr   = int'(thresh_i);
    promo = (mcnt >= thr);
    req   = s_valid & s_sop;
    cur   = pick(mbusy, mowner, mcnt, thr, req);
    have  = (cur >= 0);
    exp_rdy = have ? (3'(m_ready) << cur) : 3'b000;
    chk(s_ready == exp_rdy, mbusy ? "R4 lock ready" : "R5 ready", s_ready, exp_rdy);
    if (!mbusy && req[0] && req[1]) chk(!s_ready[1], "R3 fh held", s_ready[1], 0);
    ev = have && s_valid[cur];
    chk(m_valid == ev, (mbusy && !s_valid[mowner]) ? "R10 stall" : "R2 valid", m_valid, ev);
    if (ev) begin
      chk({m_sop, m_eop, m_data} == {s_sop[cur], s_eop[cur], s_data[cur*DW +: DW]},
          "R9 forward", {m_sop, m_eop, m_data}, {s_sop[cur], s_eop[cur], s_data[cur*DW +: DW]});
      if (!mbusy && promo && cur == 2) chk(m_data[15:14] == 2'd2, "R6 promoted", m_data[15:14], 2);
    end
    fire = ev && m_ready;
    if (m_valid && m_ready && m_sop) begin
      starts++; last_src = int'(m_data[15:14]);
      if (m_data[15:14] == 2'd2) mg++;
    end
    for (int s = 0; s < 3; s++)
      if (s_valid[s] && exp_rdy[s]) begin
        if (s_eop[s]) begin act[s] = 0; pos[s] = 0; seq[s]++; end
        else pos[s]++;
      end
    if (fire) begin
      if (!mbusy) begin
        if (cur == 2) begin if (promo) mcnt = 0; end
        else if (mcnt < thr) mcnt++;
      end
      mbusy = !s_eop[cur];
      mowner = cur;
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int s = 0; s < 3; s++) begin seq[s] = 0; pstart[s] = 0; end

    // R1: idle state after reset, then counter zero seen through priority
    do_reset();
    @(negedge clk); #1;
    chk(m_valid == 1'b0, "R1 valid", m_valid, 0);
    chk(s_ready == 3'b000, "R1 ready", s_ready, 0);
    thresh_i = 8'd1; pstart[0] = 100; pstart[2] = 100; prdy = 100; lenfix = 2;
    step();
    chk(last_src == 0, "R1 cnt zero", last_src, 0);

    // random mix, includes R10 mid-packet gaps
    do_reset();
    thresh_i = 8'd3; pstart[0] = 20; pstart[1] = 35; pstart[2] = 15;
    pgap = 10; prdy = 70; lenfix = 0;
    repeat (3000) step();

    // R7: 10:1 ratio under saturation
    do_reset();
    thresh_i = 8'd10; pstart[0] = 100; pstart[1] = 100; pstart[2] = 100;
    pgap = 0; prdy = 100; lenfix = 2;
    for (int k = 0; k < 200 && starts < 33; k++) step();
    chk(starts == 33 && mg == 3, "R7 ratio", mg, 3);

    // R8: promotion stays armed while management idle
    do_reset();
    thresh_i = 8'd2; pstart[0] = 100; pstart[1] = 0; pstart[2] = 0;
    for (int k = 0; k < 50 && starts < 2; k++) step();
    pstart[0] = 0;
    for (int k = 0; k < 50 && act[0] != 0; k++) step();
    repeat (5) step();
    pstart[0] = 100; pstart[1] = 100; pstart[2] = 100;
    step();
    chk(last_src == 2, "R8 armed", last_src, 2);
    repeat (20) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule